// File: doc/BRIEF.md
# Frame FIFO Pointer Controller

This block produces the write and read addresses for a single-channel frame memory that works as a FIFO. The write side and the read side have separate clocks. The write address advances on enabled write cycles, and the read address advances on enabled read cycles. The memory array sits outside the block. The block drives only the addresses and the per-cycle write and read strobes that go with them. An input-enable mask lets the writer keep advancing without storing anything, which gives a frozen picture.

Each side has active-low sync inputs, and a falling edge on one of them re-references the stream on that side. A clear edge moves the pointer to address zero. A set edge moves it to a supplied address. On the write side, a mark edge restarts the stream at zero. The distance between the write and read sync events sets the delay through the buffer.

The write side never stalls. Once the buffer is full, new words overwrite the oldest ones. The read side, when empty, keeps presenting the most recently written word until more data arrives. A set or clear issued while load is enabled turns this read-halt behaviour off for good. The write pointer crosses to the read clock domain in Gray code, and a registered flag reports when the read pointer equals the synchronised write pointer.

Top module: `frame_fifo_ptr_ctrl`

## Requirements
- R1: While the resets are held, `wr_addr` reads 0, `wr_we` is low and `rd_collide` is low. With nothing written and halt mode active, `rd_addr` shows DEPTH-1.
- R2: Each write cycle with `wr_en` high and no command uses the current write address and then moves the pointer up by one. The pointer wraps from DEPTH-1 to 0.
- R3: When `wr_mask` is high, `wr_we` stays low and the write pointer still advances on `wr_en`.
- R4: Once DEPTH words have been written without any reads, writing continues. `wr_we` stays high at the wrapped addresses, overwriting the oldest words.
- R5: A read cycle with `rd_en` high and data available presents the current read address with `rd_re` high, then moves the read pointer up by one.
- R6: In halt mode, when the read pointer equals the synchronised write pointer, `rd_addr` shows that pointer minus one (the last written word) and stays there on every enabled read until the write pointer moves.
- R7: A falling edge on `wr_clr_n` or `rd_clr_n` makes that cycle's address 0. An enabled cycle then continues from 1.
- R8: A falling edge on `wr_set_n` or `rd_set_n` makes that cycle's address the value on the matching set-address input. Clear takes priority over set, and set takes priority over mark.
- R9: Holding a sync input low for more than one cycle gives only one jump. The cycles after the edge advance normally.
- R10: A falling edge on `wr_mark_n` makes that write cycle's address 0. It never turns off halt mode, even when load is enabled.
- R11: A set or clear edge on either side while that side's load-enable is high turns off halt mode permanently, until reset. After that, reads move past the write pointer. The same edge with load-enable low leaves halt mode on.
- R12: `rd_collide` is high one read cycle after the read pointer has equalled the synchronised write pointer, and low one read cycle after it has not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side synchronous reset, active low |
| wr_en | input | 1 | Write cycle enable, advances the write pointer |
| wr_mask | input | 1 | Input-enable mask: suppresses the memory write strobe |
| wr_clr_n | input | 1 | Write sync, falling edge clears the write pointer |
| wr_set_n | input | 1 | Write sync, falling edge loads `wr_set_addr` |
| wr_mark_n | input | 1 | Write mark, falling edge restarts at address 0 |
| wr_set_addr | input | ADDR_W | Target address for a write set |
| wr_load_en | input | 1 | Qualifies write set/clear as halt-disabling commands |
| wr_addr | output | ADDR_W | Memory write address for this cycle |
| wr_we | output | 1 | Memory write strobe |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side synchronous reset, active low |
| rd_en | input | 1 | Read cycle enable |
| rd_clr_n | input | 1 | Read sync, falling edge clears the read pointer |
| rd_set_n | input | 1 | Read sync, falling edge loads `rd_set_addr` |
| rd_set_addr | input | ADDR_W | Target address for a read set |
| rd_load_en | input | 1 | Qualifies read set/clear as halt-disabling commands |
| rd_addr | output | ADDR_W | Memory read address for this cycle |
| rd_re | output | 1 | Memory read strobe |
| rd_collide | output | 1 | Read pointer equals synchronised write pointer (registered) |

## Verification
The assertions assume that the sync inputs are released high before reset ends. They also assume that the write pointer is quiet for several read clocks after any jump before the read side depends on its value, because a jump changes many Gray bits at once. The stimulus follows this: every write burst or write jump is followed by eight idle read cycles before reads resume. Reads near the write pointer happen only once it has settled. The expected read addresses and halt decisions are therefore computed against the final write pointer, never a value still in flight.

// File: rtl/ffpc_pkg.sv
`timescale 1ns/1ps
// Package: shared types of the frame FIFO pointer controller.
// Assumes: nothing; holds only the decoded sync command encoding.
package ffpc_pkg;

    // Decoded pointer command of one clock cycle, listed by priority.
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_CLR  = 2'd1,
        CMD_SET  = 2'd2,
        CMD_MARK = 2'd3
    } ptr_cmd_e;

endpackage

// File: rtl/ffpc_cmd_edge.sv
`timescale 1ns/1ps
// Module: ffpc_cmd_edge
// Turns three active-low sync inputs into a one-cycle pointer command
// on their falling edges, with clear over set over mark.
// Assumes: inputs synchronous to clk. The previous-value flops have no
// reset, so an input held low through reset gives no edge.
module ffpc_cmd_edge
    import ffpc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr_n,
    input  logic     set_n,
    input  logic     mark_n,
    output ptr_cmd_e cmd
);

    logic clr_d, set_d, mark_d;

    // Remember last cycle's input levels for edge detection.
    always_ff @(posedge clk) begin
        clr_d  <= clr_n;
        set_d  <= set_n;
        mark_d <= mark_n;
    end

    // Priority decode of falling edges.
    always_comb begin
        if (clr_d && !clr_n)        cmd = CMD_CLR;
        else if (set_d && !set_n)   cmd = CMD_SET;
        else if (mark_d && !mark_n) cmd = CMD_MARK;
        else                        cmd = CMD_NONE;
    end

    // R9: a level held low gives no second command.
    p_level_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && $past(!clr_n)) |-> (cmd != CMD_CLR));

endmodule

// File: rtl/ffpc_gray_sync.sv
`timescale 1ns/1ps
// Module: ffpc_gray_sync
// Carries a binary count from the source clock to the destination clock:
// registered Gray code in the source domain, two flops in the destination,
// then back to binary.
// Assumes: the source value changes by at most one per source cycle
// whenever the destination depends on it.
module ffpc_gray_sync #(
    parameter int W = 4
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic [W-1:0] src_bin,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic [W-1:0] dst_bin
);

    logic [W-1:0] gray_q, meta_q, sync_q;

    function automatic logic [W-1:0] to_bin(input logic [W-1:0] g);
        logic [W-1:0] b;
        b[W-1] = g[W-1];
        for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    // Register the Gray form in the source domain.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) gray_q <= '0;
        else            gray_q <= src_bin ^ (src_bin >> 1);
    end

    // Two-stage synchroniser in the destination domain.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_q;
            sync_q <= meta_q;
        end
    end

    assign dst_bin = to_bin(sync_q);

endmodule

// File: rtl/ffpc_wr_ctrl.sv
`timescale 1ns/1ps
// Module: ffpc_wr_ctrl
// Write pointer: advances on enabled cycles, jumps on sync commands, never
// blocks, and records a sticky flag when a load-qualified set or clear occurs.
// Assumes: all inputs synchronous to clk.
module ffpc_wr_ctrl
    import ffpc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              mask,
    input  logic              clr_n,
    input  logic              set_n,
    input  logic              mark_n,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              load_en,
    output logic [ADDR_W-1:0] addr,
    output logic              we,
    output logic [ADDR_W-1:0] ptr,
    output logic              cmd_seen
);

    ptr_cmd_e          cmd;
    logic [ADDR_W-1:0] ptr_q;
    logic              seen_q;

    ffpc_cmd_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_n  (clr_n),
        .set_n  (set_n),
        .mark_n (mark_n),
        .cmd    (cmd)
    );

    // Address used by this cycle: the jump target or the held pointer.
    always_comb begin
        case (cmd)
            CMD_CLR:  addr = '0;
            CMD_SET:  addr = set_addr;
            CMD_MARK: addr = '0;
            default:  addr = ptr_q;
        endcase
    end

    assign we = en && !mask;

    // Pointer update; full is ignored so old data is overwritten.
    always_ff @(posedge clk) begin
        if (!rst_n)  ptr_q <= '0;
        else if (en) ptr_q <= addr + 1'b1;
        else         ptr_q <= addr;
    end

    // Sticky record of a load-qualified set or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else if (load_en && (cmd == CMD_CLR || cmd == CMD_SET)) seen_q <= 1'b1;
    end

    assign ptr      = ptr_q;
    assign cmd_seen = seen_q;

    // R2: a plain enabled cycle moves the pointer by exactly one, wrapping.
    p_wr_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cmd == CMD_NONE) |=> (ptr_q == ADDR_W'($past(ptr_q) + 1'b1)));

    // R7: a clear edge addresses word zero.
    p_wr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && $past(clr_n)) |-> (addr == '0));

    // R10: a mark alone never sets the sticky flag.
    p_mark_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_q && cmd == CMD_MARK) |=> !seen_q);

endmodule

// File: rtl/ffpc_rd_ctrl.sv
`timescale 1ns/1ps
// Module: ffpc_rd_ctrl
// Read pointer: advances on enabled cycles, jumps on sync commands, and in
// halt mode freezes at the synchronised write pointer while presenting the
// last written word. Also registers the collision flag.
// Assumes: wr_ptr and wr_seen already synchronised to clk.
module ffpc_rd_ctrl
    import ffpc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clr_n,
    input  logic              set_n,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] wr_ptr,
    input  logic              wr_seen,
    output logic [ADDR_W-1:0] addr,
    output logic              re,
    output logic              collide
);

    ptr_cmd_e          cmd;
    logic [ADDR_W-1:0] ptr_q, eff;
    logic              off_q, halt_mode, hold, coll_q;

    ffpc_cmd_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_n  (clr_n),
        .set_n  (set_n),
        .mark_n (1'b1),
        .cmd    (cmd)
    );

    // Effective pointer of this cycle after any jump.
    always_comb begin
        case (cmd)
            CMD_CLR: eff = '0;
            CMD_SET: eff = set_addr;
            default: eff = ptr_q;
        endcase
    end

    assign halt_mode = !(off_q || wr_seen);
    assign hold      = halt_mode && (eff == wr_ptr);
    assign addr      = hold ? eff - 1'b1 : eff;
    assign re        = en;

    // Pointer update; frozen while holding on empty.
    always_ff @(posedge clk) begin
        if (!rst_n)           ptr_q <= '0;
        else if (en && !hold) ptr_q <= eff + 1'b1;
        else                  ptr_q <= eff;
    end

    // Sticky halt disable from a load-qualified read set or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= 1'b0;
        else if (load_en && cmd != CMD_NONE) off_q <= 1'b1;
    end

    // Registered pointer equality flag.
    always_ff @(posedge clk) begin
        if (!rst_n) coll_q <= 1'b0;
        else        coll_q <= (ptr_q == wr_ptr);
    end

    assign collide = coll_q;

    // R6: on empty in halt mode an enabled read leaves the pointer in place.
    p_hold_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && halt_mode && cmd == CMD_NONE && ptr_q == wr_ptr) |=> $stable(ptr_q));

    // R8: a set edge addresses the supplied location unless holding.
    p_rd_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_n && $past(set_n) && clr_n && !halt_mode) |-> (addr == set_addr));

endmodule

// File: rtl/frame_fifo_ptr_ctrl.sv
`timescale 1ns/1ps
// Module: frame_fifo_ptr_ctrl
// Top of the frame FIFO pointer controller: write side, read side, and the
// Gray-code crossing of the write pointer and its halt-disable flag.
// Assumes: each reset is synchronous to its own clock; the memory array
// is external and uses the address/strobe pairs directly.
module frame_fifo_ptr_ctrl #(
    parameter int ADDR_W = 20
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic              wr_mask,
    input  logic              wr_clr_n,
    input  logic              wr_set_n,
    input  logic              wr_mark_n,
    input  logic [ADDR_W-1:0] wr_set_addr,
    input  logic              wr_load_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_we,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    input  logic              rd_clr_n,
    input  logic              rd_set_n,
    input  logic [ADDR_W-1:0] rd_set_addr,
    input  logic              rd_load_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_re,
    output logic              rd_collide
);

    logic [ADDR_W-1:0] wptr, wptr_rd;
    logic              wseen, wseen_rd;

    ffpc_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .clk      (wr_clk),
        .rst_n    (wr_rst_n),
        .en       (wr_en),
        .mask     (wr_mask),
        .clr_n    (wr_clr_n),
        .set_n    (wr_set_n),
        .mark_n   (wr_mark_n),
        .set_addr (wr_set_addr),
        .load_en  (wr_load_en),
        .addr     (wr_addr),
        .we       (wr_we),
        .ptr      (wptr),
        .cmd_seen (wseen)
    );

    ffpc_gray_sync #(.W(ADDR_W)) u_ptr_sync (
        .src_clk   (wr_clk),
        .src_rst_n (wr_rst_n),
        .src_bin   (wptr),
        .dst_clk   (rd_clk),
        .dst_rst_n (rd_rst_n),
        .dst_bin   (wptr_rd)
    );

    ffpc_gray_sync #(.W(1)) u_seen_sync (
        .src_clk   (wr_clk),
        .src_rst_n (wr_rst_n),
        .src_bin   (wseen),
        .dst_clk   (rd_clk),
        .dst_rst_n (rd_rst_n),
        .dst_bin   (wseen_rd)
    );

    ffpc_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
        .clk      (rd_clk),
        .rst_n    (rd_rst_n),
        .en       (rd_en),
        .clr_n    (rd_clr_n),
        .set_n    (rd_set_n),
        .set_addr (rd_set_addr),
        .load_en  (rd_load_en),
        .wr_ptr   (wptr_rd),
        .wr_seen  (wseen_rd),
        .addr     (rd_addr),
        .re       (rd_re),
        .collide  (rd_collide)
    );

    // R3: a masked cycle never strobes the memory.
    p_mask_no_we_r3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_mask |-> !wr_we);

endmodule

// File: tb/test_frame_fifo_ptr_ctrl.sv
`timescale 1ns/1ps
// Bench: scoreboard. Driver tasks compute each cycle's expected address and
// strobe from the requirements and queue them; monitors pop and compare.
module test_frame_fifo_ptr_ctrl;

    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic          wr_en = 0, wr_mask = 0, wr_clr_n = 1, wr_set_n = 1, wr_mark_n = 1, wr_load_en = 0;
    logic [AW-1:0] wr_set_addr = '0, rd_set_addr = '0;
    logic          rd_en = 0, rd_clr_n = 1, rd_set_n = 1, rd_load_en = 0;
    logic [AW-1:0] wr_addr, rd_addr;
    logic          wr_we, rd_re, rd_collide;

    frame_fifo_ptr_ctrl #(.ADDR_W(AW)) i_frame_fifo_ptr_ctrl (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_mask(wr_mask),
        .wr_clr_n(wr_clr_n), .wr_set_n(wr_set_n), .wr_mark_n(wr_mark_n),
        .wr_set_addr(wr_set_addr), .wr_load_en(wr_load_en),
        .wr_addr(wr_addr), .wr_we(wr_we),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_clr_n(rd_clr_n),
        .rd_set_n(rd_set_n), .rd_set_addr(rd_set_addr), .rd_load_en(rd_load_en),
        .rd_addr(rd_addr), .rd_re(rd_re), .rd_collide(rd_collide)
    );

    initial forever #2.5 wr_clk = ~wr_clk;
    initial begin
        #1.2;
        forever #2.5 rd_clk = ~rd_clk;
    end

    int checks = 0, failures = 0;
    bit done = 0;

    // Expectation model state.
    int mw = 0, mr = 0;
    bit wp_clr = 1, wp_set = 1, wp_mark = 1, rp_clr = 1, rp_set = 1;
    bit wr_stk = 0, rd_stk = 0;

    logic [AW:0] wq[$];
    logic [AW:0] rq[$];
    string       wtag[$];
    string       rtag[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_step(input bit en, input bit mask, input bit clr_n, input bit set_n,
                           input bit mark_n, input int saddr, input bit ld, input string tag);
        int eff, c;
        @(negedge wr_clk);
        wr_en = en; wr_mask = mask; wr_clr_n = clr_n; wr_set_n = set_n;
        wr_mark_n = mark_n; wr_set_addr = AW'(saddr); wr_load_en = ld;
        c = 0; eff = mw;
        if (wp_clr && !clr_n)        begin eff = 0;     c = 1; end
        else if (wp_set && !set_n)   begin eff = saddr; c = 2; end
        else if (wp_mark && !mark_n) begin eff = 0;     c = 3; end
        wq.push_back({en && !mask, AW'(eff)});
        wtag.push_back(tag);
        if (ld && (c == 1 || c == 2)) wr_stk = 1;
        mw = en ? (eff + 1) % DEPTH : eff;
        wp_clr = clr_n; wp_set = set_n; wp_mark = mark_n;
    endtask

    task automatic wr_wait(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_en = 0; wr_mask = 0; wr_clr_n = 1; wr_set_n = 1; wr_mark_n = 1; wr_load_en = 0;
            wp_clr = 1; wp_set = 1; wp_mark = 1;
        end
    endtask

    task automatic rd_step(input bit en, input bit clr_n, input bit set_n, input int saddr,
                           input bit ld, input string tag);
        int eff, addr, c;
        bit hold;
        @(negedge rd_clk);
        rd_en = en; rd_clr_n = clr_n; rd_set_n = set_n; rd_set_addr = AW'(saddr); rd_load_en = ld;
        c = 0; eff = mr;
        if (rp_clr && !clr_n)      begin eff = 0;     c = 1; end
        else if (rp_set && !set_n) begin eff = saddr; c = 2; end
        hold = !(rd_stk || wr_stk) && (eff == mw);
        addr = hold ? (eff + DEPTH - 1) % DEPTH : eff;
        rq.push_back({en, AW'(addr)});
        rtag.push_back(tag);
        mr = (en && !hold) ? (eff + 1) % DEPTH : eff;
        if (ld && c != 0) rd_stk = 1;
        rp_clr = clr_n; rp_set = set_n;
    endtask

    task automatic rd_wait(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk);
            rd_en = 0; rd_clr_n = 1; rd_set_n = 1; rd_load_en = 0;
            rp_clr = 1; rp_set = 1;
        end
    endtask

    // Write-side monitor.
    initial forever begin
        @(negedge wr_clk);
        #1;
        if (wq.size() > 0) begin
            logic [AW:0] e;
            string t;
            e = wq.pop_front();
            t = wtag.pop_front();
            check({wr_we, wr_addr} == e, t, int'({wr_we, wr_addr}), int'(e));
        end
    end

    // Read-side monitor.
    initial forever begin
        @(negedge rd_clk);
        #1;
        if (rq.size() > 0) begin
            logic [AW:0] e;
            string t;
            e = rq.pop_front();
            t = rtag.pop_front();
            check({rd_re, rd_addr} == e, t, int'({rd_re, rd_addr}), int'(e));
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge wr_clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge wr_clk);
        @(negedge rd_clk); #1;
        check(wr_addr == '0, "R1 wr_addr", int'(wr_addr), 0);
        check(wr_we == 1'b0, "R1 wr_we", int'(wr_we), 0);
        check(rd_collide == 1'b0, "R1 rd_collide", int'(rd_collide), 0);
        check(rd_addr == AW'(DEPTH - 1), "R1 rd_addr", int'(rd_addr), DEPTH - 1);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        wr_wait(2); rd_wait(2);

        // R2/R3: five writes, third masked
        wr_step(1, 0, 1, 1, 1, 0, 0, "R2 write");
        wr_step(1, 0, 1, 1, 1, 0, 0, "R2 write");
        wr_step(1, 1, 1, 1, 1, 0, 0, "R3 masked write");
        wr_step(1, 0, 1, 1, 1, 0, 0, "R2 write");
        wr_step(1, 0, 1, 1, 1, 0, 0, "R2 write");
        wr_wait(2); rd_wait(8);

        // R5/R6: read past the data, hold on the last written word
        for (int i = 0; i < 7; i++) rd_step(1, 1, 1, 0, 0, i < 5 ? "R5 read" : "R6 hold");
        rd_wait(4);
        check(rd_collide == 1'b1, "R12 collide on empty", int'(rd_collide), 1);

        // More data releases the hold
        for (int i = 0; i < 3; i++) wr_step(1, 0, 1, 1, 1, 0, 0, "R2 write");
        wr_wait(2); rd_wait(8);
        for (int i = 0; i < 4; i++) rd_step(1, 1, 1, 0, 0, "R6 resume then hold");
        rd_wait(2);

        // R4: write twenty without reading, wrapping over old data
        for (int i = 0; i < 20; i++) wr_step(1, 0, 1, 1, 1, 0, 0, "R4 overwrite");
        wr_wait(2); rd_wait(8);
        check(rd_collide == 1'b0, "R12 no collide", int'(rd_collide), 0);

        // R7/R9: write clear held two cycles, load low
        wr_step(1, 0, 0, 1, 1, 0, 0, "R7 wr clear");
        wr_step(1, 0, 0, 1, 1, 0, 0, "R9 held low");
        wr_wait(2); rd_wait(8);
        // R11: halt still on, reads stop at the last written word
        for (int i = 0; i < 12; i++) rd_step(1, 1, 1, 0, 0, "R11 halt kept");
        rd_wait(4);
        check(rd_collide == 1'b1, "R12 collide after catch-up", int'(rd_collide), 1);

        // R10: mark with load high keeps halt mode
        wr_step(1, 0, 1, 1, 0, 0, 1, "R10 mark");
        wr_step(1, 0, 1, 1, 0, 0, 1, "R10 after mark");
        wr_step(1, 0, 1, 1, 1, 0, 0, "R10 after mark");
        wr_wait(2); rd_wait(8);
        // R8: read set to 1, load low
        rd_step(1, 1, 0, 1, 0, "R8 rd set");
        for (int i = 0; i < 3; i++) rd_step(1, 1, 0, 1, 0, "R10 halt kept");
        // R7: read clear, load low
        rd_step(1, 0, 1, 0, 0, "R7 rd clear");
        for (int i = 0; i < 3; i++) rd_step(1, 0, 1, 0, 0, "R9 rd held");
        rd_wait(2);

        // R8/R11: write set with load high disables halt
        wr_step(1, 0, 1, 0, 1, 9, 1, "R8 wr set");
        wr_step(1, 0, 1, 0, 1, 9, 0, "R8 after set");
        wr_wait(2); rd_wait(8);
        for (int i = 0; i < 10; i++) rd_step(1, 1, 1, 0, 0, "R11 halt off");
        rd_wait(2); wr_wait(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule